// File: doc/BRIEF.md
# Floating-Point Sign Manipulation Unit

This unit executes the register-to-register sign operations of a RISC floating-point pipeline. There are four: negate, absolute value, negative absolute value and plain move. It receives a 32-bit instruction word, the 64-bit value of the B source register and the current floating-point status/control word. It decodes the fields of the instruction and works on the raw binary64 bit pattern. It never rounds, never classifies the value and never raises a flag, so NaNs of either kind have their sign bit changed like any other value.

The decode, the result and the condition-field update are combinational. They land in a single registered output stage, so an accepted instruction presents its destination write one clock later. The index of the B source is driven straight from the instruction word, so the register file can be read in the same cycle. In the record form, the unit does not compare the result with zero. Instead it copies four existing status bits into condition field 1.

Top module: `fp_sign_unit`

## Requirements
- R1: An instruction with in_valid high, instruction bits [31:26] equal to 63 and bits [10:1] equal to 40, 264, 136 or 72 produces out_valid and dst_we high on the next clock. With in_valid low, or a primary opcode other than 63, both outputs are low on that clock.
- R2: Extended opcode 40 (negate) inverts bit 63 of the source pattern and passes bits [62:0] unchanged. This holds for zeros, infinities, denormals, and quiet and signalling NaNs.
- R3: Extended opcode 264 (absolute value) forces bit 63 of the result to 0 and copies bits [62:0].
- R4: Extended opcode 136 (negative absolute value) forces bit 63 of the result to 1 and copies bits [62:0].
- R5: Extended opcode 72 (move) copies all 64 bits unchanged.
- R6: dst_idx, registered, equals instruction bits [25:21]. src_idx, combinational, equals bits [15:11]. Bits [20:16] have no effect on any output.
- R7: When instruction bit 0 (record flag) is 1 on an accepted instruction, cr_we is high on the next clock. cr_field then holds status bits [31:28] as sampled with the instruction, ordered LT, GT, EQ, SO from bit 3 down to bit 0. When the record flag is 0, cr_we stays low.
- R8: Under primary opcode 63, any other extended opcode leaves out_valid, dst_we and cr_we low on the next clock.
- R9: A clock with rst high leaves out_valid, dst_we and cr_we low after that edge, whatever the inputs.
- R10: The result value does not depend on the status word.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word is present |
| instr | input | 32 | Instruction word |
| src_val | input | 64 | Value of the B source register |
| fpscr | input | 32 | Current status/control word |
| src_idx | output | 5 | B source register index, combinational |
| out_valid | output | 1 | Registered result is valid |
| dst_we | output | 1 | Destination register write enable |
| dst_idx | output | 5 | Destination register index |
| dst_val | output | 64 | Result bit pattern |
| cr_we | output | 1 | Condition field 1 write enable |
| cr_field | output | 4 | Value for condition field 1 |

## Verification
The bench checks src_idx in the same cycle it drives an instruction. It does this one time unit after driving on the falling edge, before any clock edge has passed. Every registered result (valid, write enables, destination index, value and condition field) is due on the first rising edge after the instruction is driven. The bench samples it on the next falling edge, exactly one clock after the drive, and then drives the next instruction. In the reset check, reset and a valid negate are applied together, and the bench confirms the outputs are low at the same sampling point.

// File: rtl/fp_sign_unit.sv
module fp_sign_unit #(
  parameter int DATA_W   = 64,
  parameter int STAT_W   = 32,
  parameter int PRI_OP   = 63,
  parameter int XO_NEG   = 40,
  parameter int XO_ABS   = 264,
  parameter int XO_NABS  = 136,
  parameter int XO_MOVE  = 72
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] src_val,
  input  logic [STAT_W-1:0] fpscr,
  output logic [4:0]        src_idx,
  output logic              out_valid,
  output logic              dst_we,
  output logic [4:0]        dst_idx,
  output logic [DATA_W-1:0] dst_val,
  output logic              cr_we,
  output logic [3:0]        cr_field
);
  localparam int OP_W = 6;
  localparam int XO_W = 10;
  localparam int CR_W = 4;

  typedef enum logic [1:0] {K_MOVE, K_NEG, K_ABS, K_NABS} kind_e;

  logic [OP_W-1:0] op_f;
  logic [XO_W-1:0] xo_f;
  logic [4:0]      rt_f;
  logic            rec_f;
  logic            known;
  kind_e           kind;
  logic            new_sign;
  logic            accept;

  assign op_f    = instr[31:26];
  assign rt_f    = instr[25:21];
  assign src_idx = instr[15:11];
  assign xo_f    = instr[10:1];
  assign rec_f   = instr[0];

  always_comb begin
    known = 1'b1;
    kind  = K_MOVE;
    if (xo_f == XO_W'(XO_NEG))       kind = K_NEG;
    else if (xo_f == XO_W'(XO_ABS))  kind = K_ABS;
    else if (xo_f == XO_W'(XO_NABS)) kind = K_NABS;
    else if (xo_f == XO_W'(XO_MOVE)) kind = K_MOVE;
    else                             known = 1'b0;
  end

  always_comb begin
    unique case (kind)
      K_NEG:   new_sign = ~src_val[DATA_W-1];
      K_ABS:   new_sign = 1'b0;
      K_NABS:  new_sign = 1'b1;
      default: new_sign = src_val[DATA_W-1];
    endcase
  end

  assign accept = in_valid && (op_f == OP_W'(PRI_OP)) && known;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst_we    <= 1'b0;
      cr_we     <= 1'b0;
    end else begin
      out_valid <= accept;
      dst_we    <= accept;
      cr_we     <= accept && rec_f;
    end
    if (accept) begin
      dst_idx  <= rt_f;
      dst_val  <= {new_sign, src_val[DATA_W-2:0]};
      cr_field <= fpscr[STAT_W-1 -: CR_W];
    end
  end
endmodule

module fp_sign_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] instr,
  input logic [63:0] src_val,
  input logic [31:0] fpscr,
  input logic        out_valid,
  input logic        dst_we,
  input logic [4:0]  dst_idx,
  input logic [63:0] dst_val,
  input logic        cr_we,
  input logic [3:0]  cr_field
);
  logic was_rst;
  always_ff @(posedge clk) was_rst <= rst;

  // R9
  always_ff @(negedge clk)
    if (was_rst === 1'b1)
      reset_quiet_chk: assert (!out_valid && !dst_we && !cr_we);

  // R1
  we_tracks_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == dst_we);

  // R2
  neg_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] == 6'd63 && instr[10:1] == 10'd40) |=>
    (out_valid && dst_val == {~$past(src_val[63]), $past(src_val[62:0])}));

  // R3
  abs_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] == 6'd63 && instr[10:1] == 10'd264) |=>
    (out_valid && dst_val == {1'b0, $past(src_val[62:0])}));

  // R4
  nabs_set_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] == 6'd63 && instr[10:1] == 10'd136) |=>
    (out_valid && dst_val == {1'b1, $past(src_val[62:0])}));

  // R6
  dst_index_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] == 6'd63 && instr[10:1] == 10'd72) |=>
    (dst_idx == $past(instr[25:21]) && dst_val == $past(src_val)));

  // R7
  record_cr_chk: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> (out_valid && cr_field == $past(fpscr[31:28])));

  // R8
  unknown_xo_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] == 6'd63 && instr[10:1] == 10'd0) |=>
    (!out_valid && !cr_we));
endmodule

bind fp_sign_unit fp_sign_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .src_val(src_val),
  .fpscr(fpscr), .out_valid(out_valid), .dst_we(dst_we), .dst_idx(dst_idx),
  .dst_val(dst_val), .cr_we(cr_we), .cr_field(cr_field)
);

// File: tb/tb_fp_sign_unit.sv
module tb_fp_sign_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr;
  logic [63:0] src_val;
  logic [31:0] fpscr;
  logic [4:0]  src_idx;
  logic        out_valid, dst_we, cr_we;
  logic [4:0]  dst_idx;
  logic [63:0] dst_val;
  logic [3:0]  cr_field;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fp_sign_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .src_val(src_val),
    .fpscr(fpscr), .src_idx(src_idx), .out_valid(out_valid), .dst_we(dst_we),
    .dst_idx(dst_idx), .dst_val(dst_val), .cr_we(cr_we), .cr_field(cr_field)
  );

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rt,
      input logic [4:0] ra, input logic [4:0] rb, input logic [9:0] xo, input logic rc);
    return {op, rt, ra, rb, xo, rc};
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    if (w[31:26] != 6'd63) return "R1";
    case (w[10:1])
      10'd40:  return "R2";
      10'd264: return "R3";
      10'd136: return "R4";
      10'd72:  return "R5";
      default: return "R8";
    endcase
  endfunction

  function automatic logic exp_ok(input logic [31:0] w);
    return w[31:26] == 6'd63 &&
      (w[10:1] == 10'd40 || w[10:1] == 10'd264 || w[10:1] == 10'd136 || w[10:1] == 10'd72);
  endfunction

  function automatic logic [63:0] exp_val(input logic [31:0] w, input logic [63:0] s);
    case (w[10:1])
      10'd40:  return {~s[63], s[62:0]};
      10'd264: return {1'b0, s[62:0]};
      10'd136: return {1'b1, s[62:0]};
      default: return s;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic v, input logic [31:0] w, input logic [63:0] s, input logic [31:0] st);
    string t;
    logic ok;
    t  = tag_of(w);
    ok = v && exp_ok(w);
    @(negedge clk);
    in_valid = v; instr = w; src_val = s; fpscr = st;
    #1 chk("R6", "src_idx", 64'(src_idx), 64'(w[15:11]));
    @(negedge clk);
    chk(v ? t : "R1", "out_valid", 64'(out_valid), 64'(ok));
    chk("R1", "dst_we", 64'(dst_we), 64'(ok));
    chk("R7", "cr_we", 64'(cr_we), 64'(ok && w[0]));
    if (ok) begin
      chk(t, "dst_val", dst_val, exp_val(w, s));
      chk("R6", "dst_idx", 64'(dst_idx), 64'(w[25:21]));
      if (w[0]) chk("R7", "cr_field", 64'(cr_field), 64'(st[31:28]));
    end
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] corners [10];
    logic [9:0]  xos [4];
    logic [31:0] w;
    logic [63:0] r0, r1;
    void'($urandom(32'd2024));
    corners = '{64'h0000000000000000, 64'h8000000000000000, 64'h7FF0000000000000,
                64'hFFF0000000000000, 64'h7FF8000000000001, 64'hFFF8000000000000,
                64'h7FF0000000000005, 64'hFFF4000000000000, 64'h000FFFFFFFFFFFFF,
                64'h8000000000000001};
    xos = '{10'd40, 10'd264, 10'd136, 10'd72};
    rst = 1'b1; in_valid = 1'b0; instr = '0; src_val = '0; fpscr = '0;
    repeat (3) @(negedge clk);
    chk("R9", "out_valid at reset", 64'(out_valid), 64'd0);
    chk("R9", "cr_we at reset", 64'(cr_we), 64'd0);
    rst = 1'b0;

    foreach (corners[i])
      foreach (xos[k])
        run(1'b1, mk(6'd63, 5'(i), 5'd31, 5'(k + 3), xos[k], 1'(i)), corners[i], 32'hA5000000);

    run(1'b0, mk(6'd63, 5'd1, 5'd0, 5'd2, 10'd40, 1'b1), 64'h1, 32'hF0000000);
    run(1'b1, mk(6'd31, 5'd1, 5'd0, 5'd2, 10'd40, 1'b1), 64'h1, 32'hF0000000);
    run(1'b1, mk(6'd63, 5'd1, 5'd0, 5'd2, 10'd0, 1'b1), 64'h1, 32'hF0000000);
    run(1'b1, mk(6'd63, 5'd1, 5'd0, 5'd2, 10'd18, 1'b0), 64'h1, 32'hF0000000);

    // R6: source A field has no effect
    run(1'b1, mk(6'd63, 5'd9, 5'd0, 5'd4, 10'd40, 1'b0), 64'h3FF0000000000000, 32'h0);
    r0 = dst_val;
    run(1'b1, mk(6'd63, 5'd9, 5'd27, 5'd4, 10'd40, 1'b0), 64'h3FF0000000000000, 32'h0);
    chk("R6", "source A ignored", dst_val, r0);
    // R10: status word does not change the result
    run(1'b1, mk(6'd63, 5'd2, 5'd0, 5'd4, 10'd264, 1'b1), 64'hFFF4000000000000, 32'h00000000);
    r1 = dst_val;
    run(1'b1, mk(6'd63, 5'd2, 5'd0, 5'd4, 10'd264, 1'b1), 64'hFFF4000000000000, 32'hFFFFFFFF);
    chk("R10", "status independent", dst_val, r1);

    // R9: reset overrides a valid instruction
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; instr = mk(6'd63, 5'd3, 5'd0, 5'd3, 10'd40, 1'b1);
    @(negedge clk);
    chk("R9", "out_valid under reset", 64'(out_valid), 64'd0);
    chk("R9", "dst_we under reset", 64'(dst_we), 64'd0);
    chk("R9", "cr_we under reset", 64'(cr_we), 64'd0);
    rst = 1'b0; in_valid = 1'b0;

    for (int n = 0; n < 400; n++) begin
      w = $urandom;
      if (($urandom % 8) != 0) w[31:26] = 6'd63;
      if (($urandom % 6) != 0) w[10:1] = xos[$urandom % 4];
      run(($urandom % 10) != 0, w, {$urandom, $urandom}, $urandom);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule